// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Flags

This block is the datapath of a small 8-bit core. It takes two operands, an operation code and the core's present carry bit. One clock edge later it presents a result byte and the zero, digit-carry and carry flags. The operations are addition and subtraction, five logical and move operations, rotates through the carry in both directions, and an 8x8 multiply in unsigned or two's-complement form. For a multiply, the high byte of the product goes to its own output register and the low byte becomes the result.

The result and the flags are registered state. An operation that does not define a flag leaves that flag at its previous value, so the flag outputs can feed the core's status register directly. The core asserts `op_valid` for each operation it wants performed. Idle cycles and unassigned operation codes leave every output unchanged. The caller does register-file access and instruction decode.

Top module: `byte_alu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result`, `mul_high`, all three flags and `res_valid` become 0.
- R2: Add (op code 0): `result` = (A+B) mod 256. `carry_flag` is set on a carry out of bit 7. `dcarry_flag` is set on a carry out of bit 3. `zero_flag` is set when `result` is 0.
- R3: Subtract (op code 1): `result` = (A-B) mod 256. `carry_flag` is 1 when no borrow leaves bit 7 (A >= B unsigned). `dcarry_flag` is 1 when no borrow leaves bit 3 (A[3:0] >= B[3:0]). `zero_flag` follows the result.
- R4: The logical and move ops are AND (2), OR (3), XOR (4), complement of A (5) and pass B (6). Each writes its result and updates `zero_flag`. Each leaves `carry_flag` and `dcarry_flag` unchanged.
- R5: Rotate right (op code 7): `result` = {carry_in, A[7:1]} and `carry_flag` = A[0]. `zero_flag` and `dcarry_flag` stay unchanged.
- R6: Rotate left (op code 8): `result` = {A[6:0], carry_in} and `carry_flag` = A[7]. `zero_flag` and `dcarry_flag` stay unchanged.
- R7: Unsigned multiply (op code 9): the 16-bit product A*B puts its low byte on `result` and its high byte on `mul_high`. `zero_flag` is set from the low byte only. `carry_flag` and `dcarry_flag` stay unchanged.
- R8: Signed multiply (op code 10) is the same as R7, except that A and B are read as two's-complement values and the product is two's complement.
- R9: `mul_high` changes only after a multiply op.
- R10: A cycle with `op_valid` low, or with an op code from 11 to 15, leaves `result`, `mul_high` and all flags unchanged and drives `res_valid` low on the next cycle.
- R11: Every accepted op shows its outputs exactly one rising edge after it is presented, with `res_valid` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Perform the presented operation this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Present carry, shifted in by rotates |
| result | output | 8 | Registered result byte |
| zero_flag | output | 1 | Zero flag |
| dcarry_flag | output | 1 | Digit (bit 3) carry flag |
| carry_flag | output | 1 | Carry flag |
| mul_high | output | 8 | High byte of the last product |
| res_valid | output | 1 | An accepted op completed on the last edge |

## Verification
Two of this block's functions can fall in the same operation, and each pair gets its own stimulus. An add of 0x88 and 0x88 carries out of both bit 3 and bit 7 at once, and the bench expects both flags set next to a nonzero result. A signed multiply of 0x80 by 0x80 gives a zero low byte and a nonzero high byte, and the bench expects the zero flag, 0x40 on the high-byte output and untouched carry flags in that one cycle. A behavioural model compares every output on every clock, through directed and random sequences that mix flag-writing and flag-preserving ops.

// File: rtl/byte_alu_pkg.sv
// Shared types for the byte arithmetic unit.
// Assumes a 4-bit operation code; codes above OP_MULS are unassigned.
package byte_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_MOV  = 4'd6,
        OP_RR   = 4'd7,
        OP_RL   = 4'd8,
        OP_MULU = 4'd9,
        OP_MULS = 4'd10
    } alu_op_e;

    // True for the codes that name an operation.
    function automatic logic op_known(input logic [3:0] code);
        return code <= 4'd10;
    endfunction
endpackage

// File: rtl/bac_addsub.sv
// Adder/subtractor split at the half-width boundary.
// Subtraction is formed as A + ~B + 1, so the carries out are the inverted borrows.
// Assumes WIDTH is even and at least 2.
module bac_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             half_carry,
    output logic             full_carry
);
    localparam int HALF = WIDTH / 2;
    localparam int UPPER = WIDTH - HALF;

    logic [WIDTH-1:0] b_eff;
    logic [HALF:0]    lo_sum;
    logic [UPPER:0]   hi_sum;

    // Lower and upper halves added in turn so the middle carry stays visible.
    always_comb begin
        b_eff  = sub ? ~b : b;
        lo_sum = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, sub};
        hi_sum = {1'b0, a[WIDTH-1:HALF]} + {1'b0, b_eff[WIDTH-1:HALF]}
               + {{UPPER{1'b0}}, lo_sum[HALF]};
        sum        = {hi_sum[UPPER-1:0], lo_sum[HALF-1:0]};
        half_carry = lo_sum[HALF];
        full_carry = hi_sum[UPPER];
    end
endmodule

// File: rtl/bac_logic.sv
// Logical, move and rotate-through-carry operations.
// A rotate shifts the incoming carry into the vacated end and returns the bit shifted out.
module bac_logic
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             rot_out
);
    // Select the bitwise or rotate result for the current op.
    always_comb begin
        res     = '0;
        rot_out = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_MOV:  res = b;
            OP_RR: begin
                res     = {cin, a[WIDTH-1:1]};
                rot_out = a[0];
            end
            OP_RL: begin
                res     = {a[WIDTH-2:0], cin};
                rot_out = a[WIDTH-1];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bac_mult.sv
// WIDTH x WIDTH multiplier giving a 2*WIDTH product.
// For signed mode both operands are sign-extended to full product width first.
module bac_mult #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               is_signed,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;

    // Extend each operand, then keep the low PW bits of the product.
    always_comb begin
        a_ext = is_signed ? {{WIDTH{a[WIDTH-1]}}, a} : {{WIDTH{1'b0}}, a};
        b_ext = is_signed ? {{WIDTH{b[WIDTH-1]}}, b} : {{WIDTH{1'b0}}, b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/byte_alu_core.sv
// Top of the byte arithmetic unit: one registered stage holding the result,
// flags and high product byte. Flags an op does not define keep their value.
// Assumes the caller holds op_sel/operands valid in the cycle op_valid is high.
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             dcarry_flag,
    output logic             carry_flag,
    output logic [WIDTH-1:0] mul_high,
    output logic             res_valid
);
    localparam int PW = 2 * WIDTH;

    alu_op_e          op;
    logic [WIDTH-1:0] as_sum;
    logic             as_half, as_full;
    logic [WIDTH-1:0] lg_res;
    logic             lg_rot;
    logic [PW-1:0]    mul_prod;

    logic [WIDTH-1:0] nx_res, nx_high;
    logic             nx_z, nx_dc, nx_c;
    logic             take;

    assign op   = alu_op_e'(op_sel);
    assign take = op_valid && op_known(op_sel);

    bac_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(op == OP_SUB),
        .sum(as_sum), .half_carry(as_half), .full_carry(as_full)
    );

    bac_logic #(.WIDTH(WIDTH)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .cin(carry_in),
        .res(lg_res), .rot_out(lg_rot)
    );

    bac_mult #(.WIDTH(WIDTH)) u_mult (
        .a(opnd_a), .b(opnd_b), .is_signed(op == OP_MULS), .prod(mul_prod)
    );

    // Choose next state for each register; unchanged by default.
    always_comb begin
        nx_res  = result;
        nx_high = mul_high;
        nx_z    = zero_flag;
        nx_dc   = dcarry_flag;
        nx_c    = carry_flag;
        if (take) begin
            case (op)
                OP_ADD, OP_SUB: begin
                    nx_res = as_sum;
                    nx_z   = (as_sum == '0);
                    nx_dc  = as_half;
                    nx_c   = as_full;
                end
                OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOV: begin
                    nx_res = lg_res;
                    nx_z   = (lg_res == '0);
                end
                OP_RR, OP_RL: begin
                    nx_res = lg_res;
                    nx_c   = lg_rot;
                end
                OP_MULU, OP_MULS: begin
                    nx_res  = mul_prod[WIDTH-1:0];
                    nx_high = mul_prod[PW-1:WIDTH];
                    nx_z    = (mul_prod[WIDTH-1:0] == '0);
                end
                default: nx_res = result;
            endcase
        end
    end

    // Output stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            mul_high    <= '0;
            zero_flag   <= 1'b0;
            dcarry_flag <= 1'b0;
            carry_flag  <= 1'b0;
            res_valid   <= 1'b0;
        end else begin
            result      <= nx_res;
            mul_high    <= nx_high;
            zero_flag   <= nx_z;
            dcarry_flag <= nx_dc;
            carry_flag  <= nx_c;
            res_valid   <= take;
        end
    end
endmodule

// File: rtl/byte_alu_checker.sv
// Temporal properties of byte_alu_core, attached by bind below.
// Assumes op codes from byte_alu_pkg.
module byte_alu_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag,
    input logic             dcarry_flag,
    input logic             carry_flag,
    input logic [WIDTH-1:0] mul_high,
    input logic             res_valid
);
    logic is_mul, known;
    assign is_mul = (op_sel == 4'd9) || (op_sel == 4'd10);
    assign known  = (op_sel <= 4'd10);

    // R2: add carry out of the top bit
    p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd0) |=>
        carry_flag == ($past({1'b0, opnd_a} + {1'b0, opnd_b}) > (WIDTH+1)'((1 << WIDTH) - 1)));

    // R3: subtract carry is the inverted borrow
    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd1) |=> carry_flag == $past(opnd_a >= opnd_b));

    // R5: rotate right moves bit 0 to carry
    p_rr_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd7) |=> carry_flag == $past(opnd_a[0]));

    // R6: rotate left moves the top bit to carry
    p_rl_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd8) |=> carry_flag == $past(opnd_a[WIDTH-1]));

    // R7: multiply keeps the carry flags
    p_mul_keeps_carries_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_mul) |=> ($stable(carry_flag) && $stable(dcarry_flag)));

    // R9: high byte moves only on a multiply
    p_high_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && is_mul) |=> $stable(mul_high));

    // R10: idle or unassigned code changes nothing
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && known) |=>
        ($stable(result) && $stable(zero_flag) && !res_valid));

    // R11: accepted op raises res_valid next cycle
    p_valid_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && known) |=> res_valid);
endmodule

bind byte_alu_core byte_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .zero_flag(zero_flag), .dcarry_flag(dcarry_flag), .carry_flag(carry_flag),
    .mul_high(mul_high), .res_valid(res_valid)
);

// File: tb/byte_alu_core_tb_top.sv
// Bench for byte_alu_core: behavioural model compared on every clock.
module byte_alu_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result, mul_high;
    logic       zero_flag, dcarry_flag, carry_flag, res_valid;

    int n_checks = 0;
    int n_fail = 0;

    // model state
    int m_res = 0, m_hi = 0, m_z = 0, m_dc = 0, m_c = 0, m_v = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .result(result), .zero_flag(zero_flag), .dcarry_flag(dcarry_flag),
        .carry_flag(carry_flag), .mul_high(mul_high), .res_valid(res_valid)
    );

    function automatic string tag_of(input int op, input int v);
        if (!v || op > 10) return "R10";
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3, 4, 5, 6: return "R4";
            7: return "R5";
            8: return "R6";
            9: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Advance the model by one accepted (or idle) cycle.
    task automatic model_step(input int op, input int a, input int b, input int ci, input int v);
        int p, sa, sb;
        if (!v || op > 10) begin
            m_v = 0;
            return;
        end
        m_v = 1;
        case (op)
            0: begin
                m_res = (a + b) % 256; m_c = (a + b) > 255;
                m_dc = ((a % 16) + (b % 16)) > 15; m_z = (m_res == 0);
            end
            1: begin
                m_res = (a - b + 256) % 256; m_c = (a >= b);
                m_dc = ((a % 16) >= (b % 16)); m_z = (m_res == 0);
            end
            2: begin m_res = a & b; m_z = (m_res == 0); end
            3: begin m_res = a | b; m_z = (m_res == 0); end
            4: begin m_res = a ^ b; m_z = (m_res == 0); end
            5: begin m_res = 255 - a; m_z = (m_res == 0); end
            6: begin m_res = b; m_z = (m_res == 0); end
            7: begin m_res = ci * 128 + a / 2; m_c = a % 2; end
            8: begin m_res = (a * 2) % 256 + ci; m_c = a / 128; end
            default: begin
                sa = (op == 10 && a > 127) ? a - 256 : a;
                sb = (op == 10 && b > 127) ? b - 256 : b;
                p = (sa * sb) & 32'hFFFF;
                m_res = p % 256; m_hi = p / 256; m_z = (m_res == 0);
            end
        endcase
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (result !== 8'(m_res) || mul_high !== 8'(m_hi) || zero_flag !== 1'(m_z) ||
            dcarry_flag !== 1'(m_dc) || carry_flag !== 1'(m_c) || res_valid !== 1'(m_v)) begin
            n_fail++;
            $display("FAIL %s: got res=%02h hi=%02h z=%0b dc=%0b c=%0b v=%0b, expected res=%02h hi=%02h z=%0d dc=%0d c=%0d v=%0d",
                     tag, result, mul_high, zero_flag, dcarry_flag, carry_flag, res_valid,
                     m_res, m_hi, m_z, m_dc, m_c, m_v);
        end
    endtask

    // Drive one cycle at the falling edge, check after the next rising edge (R11).
    task automatic step(input int op, input int a, input int b, input int ci, input int v);
        op_valid = 1'(v); op_sel = 4'(op); opnd_a = 8'(a); opnd_b = 8'(b); carry_in = 1'(ci);
        @(posedge clk);
        model_step(op, a, b, ci, v);
        @(negedge clk);
        compare(tag_of(op, v));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");                    // reset state
        rst_n = 1'b1;
        // R2: both carries at once, pure top carry with zero, nibble carry only
        step(0, 8'h88, 8'h88, 0, 1);
        step(0, 8'h80, 8'h80, 0, 1);
        step(0, 8'h0F, 8'h01, 0, 1);
        // R4: logical ops keep the carries set above
        step(2, 8'hF0, 8'h0F, 0, 1);
        step(3, 8'hA0, 8'h05, 0, 1);
        step(4, 8'h5A, 8'h5A, 0, 1);
        step(5, 8'h00, 8'h00, 0, 1);
        step(6, 8'h00, 8'h00, 0, 1);
        // R3: equal, borrow at top, borrow at nibble only
        step(1, 8'h05, 8'h05, 0, 1);
        step(1, 8'h03, 8'h05, 0, 1);
        step(1, 8'h10, 8'h01, 0, 1);
        // R5 / R6: rotate with both carry-in values
        step(7, 8'h01, 8'h00, 1, 1);
        step(7, 8'h80, 8'h00, 0, 1);
        step(8, 8'h80, 8'h00, 0, 1);
        step(8, 8'h01, 8'h00, 1, 1);
        // R7 / R8: zero low with nonzero high, extremes, signed cases
        step(9, 8'h10, 8'h10, 0, 1);
        step(9, 8'hFF, 8'hFF, 0, 1);
        step(10, 8'hFF, 8'h02, 0, 1);
        step(10, 8'h80, 8'h80, 0, 1);
        step(10, 8'h7F, 8'h80, 0, 1);
        // R9 / R10: idle cycle and unassigned codes with busy operands
        step(0, 8'h12, 8'h34, 1, 0);
        step(12, 8'hFF, 8'hFF, 1, 1);
        step(15, 8'h01, 8'h02, 0, 1);
        step(6, 8'h33, 8'h44, 0, 1);
        // mixed random traffic across all codes
        for (int i = 0; i < 400; i++)
            step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3) != 0));
        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        m_res = 0; m_hi = 0; m_z = 0; m_dc = 0; m_c = 0; m_v = 0;
        @(negedge clk);
        compare("R1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule